// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block reads from an 8-bit NAND flash device over its shared command/address/data pins. A client hands it one request at a time. A page-read request carries a 40-bit start address and a byte count. A status request carries neither. For a page read the block writes the first read command, the five address bytes and the confirm command. It then waits for the device's ready/busy line to report that the page has been loaded into the device's buffer. After that it pulses the read strobe once for each requested byte and sends the bytes to the client over a valid/ready handshake.

The device decodes each write by the two latch-select pins. A command is written with the command latch high. An address byte is written with the address latch high. Data moves with both latches low. A byte is taken by the device on the rising edge of its write strobe. The widths of the setup, pulse and hold phases of every strobe are counted in clock cycles set by parameters. The busy input comes from another clock domain, so it is synchronised before the sequencer acts on it. The sequencer also ignores the busy line for a fixed guard time after the confirm command, because the device needs a short while to pull the line low.

A status request writes one status command and reads back one byte, with no address and no busy wait. When the output register still holds a byte that the client has not taken, no further read strobe is started.

Top module: `nand_page_reader`

## Requirements
- R1: While reset is held and just after it is released, these outputs are inactive: chip enable high, write and read strobes high, both latch selects low, data drive disabled, out_valid low. req_ready is high.
- R2: A request is taken only when req_valid and req_ready are both high. req_ready stays low from the cycle after it is taken until the operation ends.
- R3: A page read latches, in this order, command 00h (command latch high, address latch low), then five address bytes with the address latch high and req_addr[7:0] first through req_addr[39:32] last, then command 30h. Each byte is taken on a write-strobe rising edge while chip enable is low.
- R4: The two latch selects are never high together. During every read strobe both latch selects are low and the data drive is off. The data drive is on during every write strobe.
- R5: Every write or read strobe stays low for exactly PULSE_CYC cycles.
- R6: After the confirm command no read strobe begins until the synchronised busy input has been seen high again. No read strobe falls while the busy input is low.
- R7: A page read returns exactly req_len bytes, in column order from the requested column. out_last is high on the final byte only. A full 2112-byte page is supported.
- R8: No read strobe falls while out_valid is high. A stalled byte stays unchanged on out_data until it is taken.
- R9: A status request (req_status=1) latches only command 70h, with no address byte and no busy wait. It returns exactly one byte with out_last high.
- R10: A page read with req_len=0 still issues the command, address and confirm writes and the busy wait. It performs no read strobe and produces no output byte.
- R11: Chip enable is low from acceptance through the final strobe of the operation, and high again once req_ready returns high.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_status | input | 1 | 1 selects a status read, 0 a page read |
| req_addr | input | 40 | Five address bytes, byte 0 in bits 7:0 |
| req_len | input | LEN_W | Number of bytes to read for a page read |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Client takes the byte |
| out_data | output | 8 | Read byte |
| out_last | output | 1 | Byte is the final one of the request |
| nand_ce_n | output | 1 | Device chip enable, active low |
| nand_cle | output | 1 | Command latch select |
| nand_ale | output | 1 | Address latch select |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Byte driven to the device |
| nand_dq_oe | output | 1 | Enable for the data drive |
| nand_dq_i | input | 8 | Byte returned by the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0), asynchronous |

## Verification
A wrong sequencer state shows on the pins within one strobe period. It appears as a latch select that is wrong or missing when the write strobe rises, as an address byte out of order, or as a read strobe that starts while the device still reports busy. Any of these lets the bench's device model log a bad command stream or a busy-time access. A wrong byte counter or output-slot state shows at the client port as a missing, extra or wrongly flagged final byte. It can also show as a read strobe during a stall, which the bench sees by the strobe count rising while out_ready is held low. Strobe-phase counter errors change the measured low width of the very next strobe.

// File: rtl/nrd_pkg.sv
`timescale 1ns/1ps
// Shared constants and state types for the NAND page read sequencer.
package nrd_pkg;
    localparam logic [7:0] CMD_READ_SETUP = 8'h00;
    localparam logic [7:0] CMD_READ_GO    = 8'h30;
    localparam logic [7:0] CMD_STATUS     = 8'h70;
    localparam int         ADDR_BYTES     = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD1, ST_ADDR, ST_CMD2, ST_GUARD, ST_WAIT_RDY, ST_READ
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD
    } strobe_phase_t;
endpackage

// File: rtl/nrd_rb_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for the device ready/busy line.
// Assumes STAGES >= 2; the chain resets to "ready" (1).
module nrd_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_async,
    output logic ready
);
    logic [STAGES-1:0] pipe;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], rb_n_async};
    end

    assign ready = pipe[STAGES-1];
endmodule

// File: rtl/nrd_strobe.sv
`timescale 1ns/1ps
// Strobe timing engine: when idle and go is high, runs setup, pulse and
// hold phases of SETUP_CYC, PULSE_CYC and HOLD_CYC cycles; the strobe is
// low during the pulse phase only. Assumes every count is at least 1.
module nrd_strobe
    import nrd_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic strobe_n,
    output logic capture,
    output logic done
);
    localparam int M1    = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAXC  = (M1 > HOLD_CYC) ? M1 : HOLD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    strobe_phase_t    phase;
    logic [CNT_W-1:0] cnt;

    // Step through the phases, reloading the down-counter at each change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (go) begin
                    phase <= PH_SETUP;
                    cnt   <= CNT_W'(SETUP_CYC - 1);
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_PULSE;
                    cnt   <= CNT_W'(PULSE_CYC - 1);
                end else cnt <= cnt - CNT_W'(1);
                PH_PULSE: if (cnt == '0) begin
                    phase <= PH_HOLD;
                    cnt   <= CNT_W'(HOLD_CYC - 1);
                end else cnt <= cnt - CNT_W'(1);
                default: if (cnt == '0) phase <= PH_IDLE;
                         else cnt <= cnt - CNT_W'(1);
            endcase
        end
    end

    assign strobe_n = (phase != PH_PULSE);
    assign capture  = (phase == PH_PULSE) && (cnt == '0);
    assign done     = (phase == PH_HOLD) && (cnt == '0);

    // Count consecutive low cycles of the strobe for the width check.
    logic [CNT_W:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)        low_run <= '0;
        else if (!strobe_n) low_run <= low_run + (CNT_W+1)'(1);
        else               low_run <= '0;
    end

    // R5: each strobe is low for exactly PULSE_CYC cycles.
    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n) |-> (low_run == (CNT_W+1)'(PULSE_CYC)));
endmodule

// File: rtl/nrd_addr_mux.sv
`timescale 1ns/1ps
// Selects one address byte per address cycle, byte 0 from the lowest bits.
module nrd_addr_mux #(
    parameter int NBYTES = 5,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic [8*NBYTES-1:0] addr,
    input  logic [IDX_W-1:0]    idx,
    output logic [7:0]          byte_out
);
    logic [7:0] lanes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = addr[8*g +: 8];
    end

    // Pick the lane for the current address cycle.
    always_comb begin
        byte_out = 8'h00;
        if (32'(idx) < NBYTES) byte_out = lanes[idx];
    end
endmodule

// File: rtl/nand_page_reader.sv
`timescale 1ns/1ps
// NAND page read sequencer. Issues command / five address / confirm write
// cycles, waits for the synchronised ready line, then strobes out bytes into
// a one-entry output register with a valid/ready handshake. Assumes one
// 8-bit device and that nand_rb_n is asynchronous to clk.
module nand_page_reader
    import nrd_pkg::*;
#(
    parameter int LEN_W       = 12,
    parameter int SETUP_CYC   = 1,
    parameter int PULSE_CYC   = 3,
    parameter int HOLD_CYC    = 1,
    parameter int GUARD_CYC   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_status,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_i,
    input  logic              nand_rb_n
);
    localparam int IDX_W  = $clog2(ADDR_BYTES);
    localparam int GCNT_W = $clog2(GUARD_CYC + 1);

    seq_state_t        state;
    logic              status_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain;
    logic [IDX_W-1:0]  idx;
    logic [GCNT_W-1:0] guard;
    logic              rb_ready;
    logic              strb_go, strb_n, strb_capture, strb_done;
    logic              write_phase;
    logic [7:0]        addr_byte;

    nrd_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rb_n_async(nand_rb_n), .ready(rb_ready)
    );

    nrd_strobe #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)) u_strobe (
        .clk(clk), .rst_n(rst_n), .go(strb_go),
        .strobe_n(strb_n), .capture(strb_capture), .done(strb_done)
    );

    nrd_addr_mux #(.NBYTES(ADDR_BYTES)) u_amux (
        .addr(addr_q), .idx(idx), .byte_out(addr_byte)
    );

    assign write_phase = (state == ST_CMD1) || (state == ST_ADDR) || (state == ST_CMD2);
    // Start a strobe for every write cycle, and for a read once the slot is free.
    assign strb_go = write_phase || ((state == ST_READ) && !out_valid);

    // Main sequencer: command, address, confirm, guard, busy wait, data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            status_q <= 1'b0;
            addr_q   <= '0;
            remain   <= '0;
            idx      <= '0;
            guard    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    status_q <= req_status;
                    addr_q   <= req_addr;
                    remain   <= req_status ? LEN_W'(1) : req_len;
                    idx      <= '0;
                    state    <= ST_CMD1;
                end
                ST_CMD1: if (strb_done) state <= status_q ? ST_READ : ST_ADDR;
                ST_ADDR: if (strb_done) begin
                    if (idx == IDX_W'(ADDR_BYTES - 1)) state <= ST_CMD2;
                    else idx <= idx + IDX_W'(1);
                end
                ST_CMD2: if (strb_done) begin
                    state <= ST_GUARD;
                    guard <= GCNT_W'(GUARD_CYC - 1);
                end
                ST_GUARD: if (guard == '0) state <= ST_WAIT_RDY;
                          else guard <= guard - GCNT_W'(1);
                ST_WAIT_RDY: if (rb_ready) state <= (remain == '0) ? ST_IDLE : ST_READ;
                ST_READ: if (strb_done) begin
                    remain <= remain - LEN_W'(1);
                    if (remain == LEN_W'(1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // One-entry output slot loaded on the read strobe's rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
            out_last  <= 1'b0;
        end else if ((state == ST_READ) && strb_capture) begin
            out_valid <= 1'b1;
            out_data  <= nand_dq_i;
            out_last  <= (remain == LEN_W'(1));
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Pin decode from the sequencer state and strobe engine.
    always_comb begin
        nand_dq_o = 8'h00;
        case (state)
            ST_CMD1: nand_dq_o = status_q ? CMD_STATUS : CMD_READ_SETUP;
            ST_ADDR: nand_dq_o = addr_byte;
            ST_CMD2: nand_dq_o = CMD_READ_GO;
            default: nand_dq_o = 8'h00;
        endcase
    end

    assign req_ready  = (state == ST_IDLE);
    assign nand_ce_n  = (state == ST_IDLE);
    assign nand_cle   = (state == ST_CMD1) || (state == ST_CMD2);
    assign nand_ale   = (state == ST_ADDR);
    assign nand_we_n  = write_phase ? strb_n : 1'b1;
    assign nand_re_n  = (state == ST_READ) ? strb_n : 1'b1;
    assign nand_dq_oe = write_phase;

    // R4: a read strobe never overlaps a latch select or the data drive.
    a_r4_read_pins_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> (!nand_cle && !nand_ale && !nand_dq_oe));

    // R8: no read strobe while an untaken byte sits in the slot.
    a_r8_no_re_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !out_valid);

    // R6: page-read strobes only once the synchronised ready is seen.
    a_r6_no_re_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_re_n && !status_q) |-> rb_ready);

    // R2: a taken request closes the request port and enables the device.
    a_r2_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !nand_ce_n));
endmodule

// File: tb/nand_page_reader_bench.sv
`timescale 1ns/1ps
// Directed bench with a behavioural NAND device model.
module nand_page_reader_bench;
    localparam int PULSE = 3;
    localparam int T_R   = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0, req_status = 1'b0, out_ready = 1'b0;
    logic [39:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic        req_ready, out_valid, out_last;
    logic [7:0]  out_data;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = 8'h00;
    logic        nand_rb_n = 1'b1;

    nand_page_reader #(.PULSE_CYC(PULSE)) u_nand_page_reader (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_status(req_status),
        .req_addr(req_addr), .req_len(req_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
    );

    int checks = 0, fails = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] page_byte(input logic [23:0] row, input logic [15:0] col);
        return row[7:0] ^ row[15:8] ^ col[7:0] ^ {col[11:8], 4'hA};
    endfunction

    // ---------------- device model (samples on the falling clock edge) ----
    int        cyc = 0;
    int        seq_kind [64];
    logic [7:0] seq_val [64];
    int        n_seq = 0;
    logic [7:0] alat [5];
    int        n_alat = 0;
    logic      status_mode = 1'b0;
    logic [23:0] m_row = '0;
    logic [15:0] m_col = '0;
    int        ptr = 0, busy_cnt = 0, busy_starts = 0;
    int        re_falls = 0, busy_viol = 0, pin_viol = 0, width_bad = 0;
    int        rb_rise_cyc = 0, first_re_cyc = -1;
    logic      prev_we = 1'b1, prev_re = 1'b1;
    int        we_low = 0, re_low = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (nand_cle && nand_ale) pin_viol <= pin_viol + 1;
        if (!nand_re_n && (nand_cle || nand_ale || nand_dq_oe)) pin_viol <= pin_viol + 1;
        if (!nand_we_n && !nand_dq_oe) pin_viol <= pin_viol + 1;
        if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
            if (busy_cnt == 1) begin nand_rb_n <= 1'b1; rb_rise_cyc <= cyc; end
        end
        we_low <= nand_we_n ? 0 : we_low + 1;
        re_low <= nand_re_n ? 0 : re_low + 1;
        if (!prev_we && nand_we_n) begin
            if (we_low != PULSE) width_bad <= width_bad + 1;
            if (!nand_ce_n && nand_cle && !nand_ale) begin
                seq_kind[n_seq] <= 1; seq_val[n_seq] <= nand_dq_o; n_seq <= n_seq + 1;
                if (nand_dq_o == 8'h00) begin status_mode <= 1'b0; n_alat <= 0; end
                if (nand_dq_o == 8'h70) status_mode <= 1'b1;
                if (nand_dq_o == 8'h30) begin
                    m_col <= {alat[1], alat[0]};
                    m_row <= {alat[4], alat[3], alat[2]};
                    ptr <= 0; nand_rb_n <= 1'b0; busy_cnt <= T_R;
                    busy_starts <= busy_starts + 1; first_re_cyc <= -1;
                end
            end else if (!nand_ce_n && nand_ale && !nand_cle) begin
                seq_kind[n_seq] <= 2; seq_val[n_seq] <= nand_dq_o; n_seq <= n_seq + 1;
                if (n_alat < 5) alat[n_alat] <= nand_dq_o;
                n_alat <= n_alat + 1;
            end
        end
        if (prev_re && !nand_re_n && !nand_ce_n) begin
            re_falls <= re_falls + 1;
            if (!nand_rb_n) busy_viol <= busy_viol + 1;
            if (first_re_cyc < 0) first_re_cyc <= cyc;
            nand_dq_i <= status_mode ? (nand_rb_n ? 8'hE0 : 8'h80)
                                     : page_byte(m_row, m_col + 16'(ptr));
        end
        if (!prev_re && nand_re_n) begin
            if (re_low != PULSE) width_bad <= width_bad + 1;
            ptr <= ptr + 1;
        end
        prev_we <= nand_we_n;
        prev_re <= nand_re_n;
    end

    // ---------------- helpers ----------------
    task automatic issue(input logic st, input logic [39:0] a, input logic [11:0] len);
        int t = 0;
        @(negedge clk);
        while (!req_ready && t < 50000) begin @(negedge clk); t++; end
        req_status = st; req_addr = a; req_len = len; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (!req_ready && t < 50000) begin @(negedge clk); t++; end
        chk("R11", "returned to idle", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic collect(input int n, input int mode, input logic [23:0] row,
                           input logic [15:0] col, input string req);
        int got = 0, bad = 0, lastbad = 0, t = 0;
        while (got < n && t < 40000) begin
            @(negedge clk); t++;
            out_ready = (mode == 0) ? 1'b1 : t[0];
            if (out_valid && out_ready) begin
                if (out_data !== page_byte(row, col + 16'(got))) bad++;
                if (out_last !== (got == n - 1)) lastbad++;
                got++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(req, "byte count", 32'(got), 32'(n));
        chk(req, "data mismatches", 32'(bad), 32'd0);
        chk("R7", "last flag misplacements", 32'(lastbad), 32'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "ce_n", {31'd0, nand_ce_n}, 32'd1);
        chk("R1", "we_n", {31'd0, nand_we_n}, 32'd1);
        chk("R1", "re_n", {31'd0, nand_re_n}, 32'd1);
        chk("R1", "cle|ale", {31'd0, nand_cle | nand_ale}, 32'd0);
        chk("R1", "dq_oe", {31'd0, nand_dq_oe}, 32'd0);
        chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_page_read();
        int b = n_seq, badseq = 0;
        logic [7:0] ev [7];
        int ek [7];
        ev = '{8'h00, 8'h10, 8'h00, 8'h01, 8'h02, 8'h03, 8'h30};
        ek = '{1, 2, 2, 2, 2, 2, 1};
        issue(1'b0, 40'h03_02_01_00_10, 12'd6);
        chk("R2", "req_ready after accept", {31'd0, req_ready}, 32'd0);
        chk("R11", "ce_n during op", {31'd0, nand_ce_n}, 32'd0);
        collect(6, 0, 24'h030201, 16'h0010, "R7");
        wait_idle();
        chk("R3", "latched cycles", 32'(n_seq - b), 32'd7);
        for (int i = 0; i < 7; i++)
            if (seq_kind[b+i] != ek[i] || seq_val[b+i] != ev[i]) badseq++;
        chk("R3", "command/address order errors", 32'(badseq), 32'd0);
        chk("R6", "strobes while busy", 32'(busy_viol), 32'd0);
        chk("R6", "first strobe after ready+sync", {31'd0, first_re_cyc >= rb_rise_cyc + 2}, 32'd1);
        chk("R4", "pin violations", 32'(pin_viol), 32'd0);
        chk("R5", "strobe width errors", 32'(width_bad), 32'd0);
        chk("R11", "ce_n after op", {31'd0, nand_ce_n}, 32'd1);
    endtask

    task automatic t_stall();
        int rf0, t = 0;
        logic [7:0] d0;
        out_ready = 1'b0;
        issue(1'b0, 40'h00_00_07_00_20, 12'd4);
        while (!out_valid && t < 5000) begin @(negedge clk); t++; end
        rf0 = re_falls; d0 = out_data;
        repeat (20) @(negedge clk);
        chk("R8", "strobes during stall", 32'(re_falls - rf0), 32'd0);
        chk("R8", "stalled byte held", {24'd0, out_data}, {24'd0, d0});
        chk("R8", "valid held", {31'd0, out_valid}, 32'd1);
        collect(4, 1, 24'h000007, 16'h0020, "R8");
        wait_idle();
        chk("R6", "strobes while busy", 32'(busy_viol), 32'd0);
    endtask

    task automatic t_status();
        int b = n_seq, bs = busy_starts, t = 0;
        issue(1'b1, 40'hFF_FF_FF_FF_FF, 12'd9);
        out_ready = 1'b1;
        while (!out_valid && t < 5000) begin @(negedge clk); t++; end
        chk("R9", "status byte", {24'd0, out_data}, 32'hE0);
        chk("R9", "status last", {31'd0, out_last}, 32'd1);
        @(negedge clk);
        out_ready = 1'b0;
        wait_idle();
        chk("R9", "latched cycles", 32'(n_seq - b), 32'd1);
        chk("R9", "command value", {24'd0, seq_val[b]}, 32'h70);
        chk("R9", "busy waits started", 32'(busy_starts - bs), 32'd0);
        chk("R9", "extra output bytes", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_zero_len();
        int b = n_seq, rf0 = re_falls, seen = 0, t = 0;
        issue(1'b0, 40'h00_00_02_00_00, 12'd0);
        out_ready = 1'b1;
        while (!req_ready && t < 5000) begin
            @(negedge clk); t++;
            if (out_valid) seen++;
        end
        out_ready = 1'b0;
        chk("R10", "write cycles", 32'(n_seq - b), 32'd7);
        chk("R10", "read strobes", 32'(re_falls - rf0), 32'd0);
        chk("R10", "output bytes", 32'(seen), 32'd0);
    endtask

    task automatic t_full_page();
        issue(1'b0, 40'h00_00_40_00_00, 12'd2112);
        collect(2112, 0, 24'h000040, 16'h0000, "R7");
        wait_idle();
        chk("R5", "strobe width errors", 32'(width_bad), 32'd0);
        chk("R4", "pin violations", 32'(pin_viol), 32'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page_read();
        t_stall();
        t_status();
        t_zero_len();
        t_full_page();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1_900_000;
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule